// File: doc/BRIEF.md
# Multi-Source Entropy CRC Whitener

This block merges several raw noise bit streams into a wide random word. Each stream has its own enable. On every clock the enabled bits are XORed into one conditioned bit, and that bit is clocked into a 64-bit CRC register with a fixed feedback polynomial. The CRC register is the random value that the read port returns.

A configuration port sets the read mode, the source enables, a minimum read spacing, an oscillator setting and an output-select code. Each source keeps its own oscillator setting. That setting is loaded by a configuration write in which exactly one enable bit is set. A full bring-up is therefore three single-source writes, one for each oscillator, followed by a write that enables all sources together. The oscillator settings are driven out to the noise cells, which sit outside this block. In interlocked mode a read is granted only after enough cycles have passed since the previous read for fresh entropy to collect. In diagnostic mode a read is granted at once.

Top module: `rngw_top`

## Requirements
- R1: After reset, rd_ack and rd_data are 0, every oscillator setting is 0, all enables are clear, the spacing is 0, the mode is interlocked, the output select is 0 (pass) and the CRC holds the nonzero SEED parameter.
- R2: The conditioned bit of a cycle is the XOR of raw_bits[i] AND the enable of source i, taken over all sources. Configuration takes effect from the clock edge that follows the write edge.
- R3: On each clock edge the CRC state S becomes (S<<1) XOR (POLY if S[63] XOR the conditioned bit is 1, else 0), where POLY = 64'h231DCEE91262B8A3 (x^64 implied).
- R4: A read is granted on a clock edge where rd_req is high. rd_ack is then high for exactly the following cycle, and rd_data carries the CRC state from just before that edge.
- R5: In interlocked mode (cfg_interlock=1), with rd_req held high, successive acknowledges are max(WAIT+1, 2) cycles apart. A granted read restarts the spacing count.
- R6: In diagnostic mode (cfg_interlock=0) the spacing value is ignored. With rd_req held high, acknowledges are 2 cycles apart.
- R7: A write with exactly one enable bit set (bit i) loads cfg_vco into the setting of source i, visible on vco_sel[i*VCO_W +: VCO_W].
- R8: A write with zero enable bits or with more than one enable bit set leaves every oscillator setting unchanged.
- R9: While the output select is 3 (mute), a granted read returns 0 and the CRC keeps advancing. Select values 0 to 2 pass the CRC state.
- R10: rd_ack is never high unless rd_req was high at the previous edge, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_bits | input | NSRC | Raw noise bits, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_interlock | input | 1 | 1 = interlocked reads, 0 = diagnostic |
| cfg_src_en | input | NSRC | Source enables |
| cfg_wait | input | WAIT_W | Minimum cycles between reads |
| cfg_vco | input | VCO_W | Oscillator setting for a single-source write |
| cfg_osel | input | 2 | Output select, 3 = mute |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_ack | output | 1 | One-cycle read acknowledge |
| rd_data | output | DATA_W | Random word of the last granted read |
| vco_sel | output | NSRC*VCO_W | Per-source oscillator settings |

## Verification
The assertions assume that the requester holds rd_req until rd_ack and may raise it again at any time. They also assume that configuration writes can arrive on any cycle, including a cycle in which a read is granted. The stimulus keeps to these rules. Requests and writes arrive at random, with spacing values kept small so that many reads complete. Directed runs hold rd_req high and do not write the configuration while acknowledge spacing is being measured.

// File: rtl/rngw_pkg.sv
package rngw_pkg;
   localparam int OSEL_W = 2;
   typedef logic [OSEL_W-1:0] osel_t;
   localparam osel_t OSEL_PASS = 2'd0;
   localparam osel_t OSEL_MUTE = 2'd3;

   localparam logic [63:0] CRC64_POLY = 64'h231DCEE91262B8A3;
   localparam logic [63:0] CRC64_SEED = 64'h0123456789ABCDEF;
endpackage

// File: rtl/rngw_mixer.sv
module rngw_mixer #(
   parameter int NSRC = 3
) (
   input  logic [NSRC-1:0] raw_bits,
   input  logic [NSRC-1:0] src_en,
   output logic            mix_bit
);
   logic [NSRC-1:0] gated;

   generate
      if (NSRC < 1) begin : g_bad
         $error("rngw_mixer: NSRC must be at least 1");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_gate
         assign gated[i] = raw_bits[i] & src_en[i];
      end
   endgenerate

   assign mix_bit = ^gated;
endmodule

// File: rtl/rngw_crc.sv
module rngw_crc #(
   parameter int              DATA_W = 64,
   parameter logic [DATA_W-1:0] POLY = rngw_pkg::CRC64_POLY,
   parameter logic [DATA_W-1:0] SEED = rngw_pkg::CRC64_SEED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   output logic [DATA_W-1:0] state
);
   logic              fb;
   logic [DATA_W-1:0] nxt;

   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("rngw_crc: DATA_W too small");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("rngw_crc: polynomial needs a constant term");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("rngw_crc: seed must be nonzero");
      end
   endgenerate

   always_comb begin
      fb  = state[DATA_W-1] ^ din;
      nxt = {state[DATA_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SEED;
      else     state <= nxt;
   end
endmodule

// File: rtl/rngw_ctl.sv
module rngw_ctl #(
   parameter int NSRC   = 3,
   parameter int WAIT_W = 16,
   parameter int VCO_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cfg_we,
   input  logic                  cfg_interlock,
   input  logic [NSRC-1:0]       cfg_src_en,
   input  logic [WAIT_W-1:0]     cfg_wait,
   input  logic [VCO_W-1:0]      cfg_vco,
   input  rngw_pkg::osel_t       cfg_osel,
   output logic                  interlock_q,
   output logic [NSRC-1:0]       src_en_q,
   output logic [WAIT_W-1:0]     wait_q,
   output rngw_pkg::osel_t       osel_q,
   output logic [NSRC*VCO_W-1:0] vco_sel
);
   localparam int VCO_TOT = NSRC * VCO_W;

   generate
      if (WAIT_W < 1 || VCO_W < 1) begin : g_bad
         $error("rngw_ctl: field widths must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         interlock_q <= 1'b1;
         src_en_q    <= '0;
         wait_q      <= '0;
         osel_q      <= rngw_pkg::OSEL_PASS;
      end else if (cfg_we) begin
         interlock_q <= cfg_interlock;
         src_en_q    <= cfg_src_en;
         wait_q      <= cfg_wait;
         osel_q      <= cfg_osel;
      end
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_vco
         logic [VCO_W-1:0] vco_r;
         logic             hit;
         assign hit = cfg_we && (cfg_src_en == (NSRC'(1) << i));
         always_ff @(posedge clk) begin
            if (rst)      vco_r <= '0;
            else if (hit) vco_r <= cfg_vco;
         end
         assign vco_sel[i*VCO_W +: VCO_W] = vco_r;
      end
   endgenerate

   AST_VCO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && ($countones(cfg_src_en) != 1)) |=> $stable(vco_sel)); // R8

   logic [VCO_TOT-1:0] unused_chk;
   assign unused_chk = vco_sel;
endmodule

// File: rtl/rngw_gate.sv
module rngw_gate #(
   parameter int DATA_W = 64,
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              interlock,
   input  logic [WAIT_W-1:0] wait_cyc,
   input  logic              mute,
   input  logic [DATA_W-1:0] crc_state,
   input  logic              rd_req,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [WAIT_W-1:0] CNT_MAX = '1;

   logic [WAIT_W-1:0] elapsed;
   logic              ready;
   logic              grant;

   assign ready = !interlock || (elapsed >= wait_cyc);
   assign grant = rd_req && !rd_ack && ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         elapsed <= '0;
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= grant;
         if (grant) begin
            rd_data <= mute ? '0 : crc_state;
            elapsed <= '0;
         end else if (elapsed != CNT_MAX) begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> $past(rd_req)); // R10
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rd_ack |=> !rd_ack); // R10
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> (elapsed == '0)); // R5
   AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_ack && $past(mute)) |-> (rd_data == '0)); // R9
endmodule

// File: rtl/rngw_top.sv
module rngw_top #(
   parameter int                NSRC   = 3,
   parameter int                DATA_W = 64,
   parameter int                WAIT_W = 16,
   parameter int                VCO_W  = 2,
   parameter logic [DATA_W-1:0] POLY   = rngw_pkg::CRC64_POLY,
   parameter logic [DATA_W-1:0] SEED   = rngw_pkg::CRC64_SEED
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NSRC-1:0]       raw_bits,
   input  logic                  cfg_we,
   input  logic                  cfg_interlock,
   input  logic [NSRC-1:0]       cfg_src_en,
   input  logic [WAIT_W-1:0]     cfg_wait,
   input  logic [VCO_W-1:0]      cfg_vco,
   input  logic [1:0]            cfg_osel,
   input  logic                  rd_req,
   output logic                  rd_ack,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NSRC*VCO_W-1:0] vco_sel
);
   logic              interlock_q;
   logic [NSRC-1:0]   src_en_q;
   logic [WAIT_W-1:0] wait_q;
   rngw_pkg::osel_t   osel_q;
   logic              mix_bit;
   logic [DATA_W-1:0] crc_state;

   rngw_ctl #(.NSRC(NSRC), .WAIT_W(WAIT_W), .VCO_W(VCO_W)) u_ctl (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_interlock(cfg_interlock),
      .cfg_src_en(cfg_src_en), .cfg_wait(cfg_wait), .cfg_vco(cfg_vco),
      .cfg_osel(cfg_osel), .interlock_q(interlock_q), .src_en_q(src_en_q),
      .wait_q(wait_q), .osel_q(osel_q), .vco_sel(vco_sel)
   );

   rngw_mixer #(.NSRC(NSRC)) u_mix (
      .raw_bits(raw_bits), .src_en(src_en_q), .mix_bit(mix_bit)
   );

   rngw_crc #(.DATA_W(DATA_W), .POLY(POLY), .SEED(SEED)) u_crc (
      .clk(clk), .rst(rst), .din(mix_bit), .state(crc_state)
   );

   rngw_gate #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_gate (
      .clk(clk), .rst(rst), .interlock(interlock_q), .wait_cyc(wait_q),
      .mute(osel_q == rngw_pkg::OSEL_MUTE), .crc_state(crc_state),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
   );
endmodule

// File: tb/tb_rngw_top.sv
module tb_rngw_top;
   localparam logic [63:0] P = 64'h231DCEE91262B8A3;
   localparam logic [63:0] S0 = 64'h0123456789ABCDEF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  raw_bits = '0;
   logic        cfg_we = 1'b0;
   logic        cfg_interlock = 1'b1;
   logic [2:0]  cfg_src_en = '0;
   logic [15:0] cfg_wait = '0;
   logic [1:0]  cfg_vco = '0;
   logic [1:0]  cfg_osel = '0;
   logic        rd_req = 1'b0;
   logic        rd_ack;
   logic [63:0] rd_data;
   logic [5:0]  vco_sel;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rngw_top dut (
      .clk(clk), .rst(rst), .raw_bits(raw_bits), .cfg_we(cfg_we),
      .cfg_interlock(cfg_interlock), .cfg_src_en(cfg_src_en),
      .cfg_wait(cfg_wait), .cfg_vco(cfg_vco), .cfg_osel(cfg_osel),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .vco_sel(vco_sel)
   );

   function automatic logic [63:0] crc_step(logic [63:0] s, logic b);
      return {s[62:0], 1'b0} ^ ((s[63] ^ b) ? P : 64'd0);
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bench-side model of the CRC and configuration (R2, R3)
   logic [63:0] m_crc;
   logic [2:0]  m_en;
   logic        m_mute;
   logic [63:0] h_crc;
   logic        h_mute;
   logic        h_req;

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_crc = S0; m_en = '0; m_mute = 0; h_req = 0;
      end else begin
         h_crc  = m_crc;
         h_mute = m_mute;
         h_req  = rd_req;
         m_crc  = crc_step(m_crc, ^(raw_bits & m_en));
         if (cfg_we) begin
            m_en   = cfg_src_en;
            m_mute = (cfg_osel == 2'd3);
         end
      end
   end

   // output monitor and raw noise driver
   bit prev_ack = 0;
   always @(negedge clk) begin
      if (!rst && rd_ack) begin
         chk("R2 R3 R4 R9 data", rd_data, h_mute ? 64'd0 : h_crc);
         chk("R10 req before ack", {63'd0, h_req}, 64'd1);
         chk("R10 single-cycle ack", {63'd0, prev_ack}, 64'd0);
      end
      prev_ack = rd_ack;
      raw_bits = 3'($urandom);
   end

   task automatic cfg(bit il, logic [2:0] en, int w, logic [1:0] v, logic [1:0] os);
      @(negedge clk);
      cfg_we = 1; cfg_interlock = il; cfg_src_en = en;
      cfg_wait = 16'(w); cfg_vco = v; cfg_osel = os;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic held(int n, int exp_gap, string tag);
      int seen = 0;
      int last = 0;
      rd_req = 1;
      while (seen < n) begin
         @(negedge clk);
         if (rd_ack) begin
            if (seen > 0) chk(tag, 64'(cyc - last), 64'(exp_gap));
            last = cyc;
            seen++;
         end
      end
      rd_req = 0;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst = 0;
      chk("R1 ack at reset", {63'd0, rd_ack}, 64'd0);
      chk("R1 data at reset", rd_data, 64'd0);
      chk("R1 vco at reset", {58'd0, vco_sel}, 64'd0);
      held(2, 2, "R1 R5 spacing zero after reset");

      // R7 per-source oscillator loads
      cfg(1, 3'b001, 0, 2'd1, 0);
      cfg(1, 3'b010, 0, 2'd2, 0);
      cfg(1, 3'b100, 0, 2'd3, 0);
      chk("R7 vco bank", {58'd0, vco_sel}, {58'd0, 6'b111001});
      cfg(1, 3'b111, 0, 2'd0, 0);
      chk("R8 all-enable write", {58'd0, vco_sel}, {58'd0, 6'b111001});
      cfg(1, 3'b000, 0, 2'd2, 0);
      chk("R8 no-enable write", {58'd0, vco_sel}, {58'd0, 6'b111001});
      cfg(1, 3'b011, 0, 2'd0, 0);
      chk("R8 two-enable write", {58'd0, vco_sel}, {58'd0, 6'b111001});

      // R5 interlock spacing
      cfg(1, 3'b111, 5, 2'd0, 0);
      held(4, 6, "R5 spacing wait=5");
      cfg(1, 3'b101, 0, 2'd0, 1);
      held(3, 2, "R5 spacing wait=0");
      cfg(1, 3'b011, 1, 2'd0, 2);
      held(3, 2, "R5 spacing wait=1");
      cfg(1, 3'b110, 12, 2'd0, 0);
      held(3, 13, "R5 spacing wait=12");

      // R6 diagnostic mode ignores spacing
      cfg(0, 3'b111, 9, 2'd0, 0);
      held(4, 2, "R6 diagnostic spacing");

      // R9 mute then pass
      cfg(0, 3'b111, 0, 2'd0, 3);
      held(3, 2, "R9 mute spacing");
      cfg(1, 3'b111, 3, 2'd0, 0);
      held(3, 4, "R9 pass after mute");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (($urandom % 20) == 0) begin
            cfg_we = 1; cfg_interlock = 1'($urandom);
            cfg_src_en = 3'($urandom); cfg_wait = 16'($urandom % 6);
            cfg_vco = 2'($urandom); cfg_osel = 2'($urandom);
         end else begin
            cfg_we = 0;
         end
         if (rd_ack) rd_req = 0;
         else if (!rd_req) rd_req = 1'($urandom);
      end
      cfg_we = 0; rd_req = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule